// File: doc/BRIEF.md
# Left-to-Right Double-and-Add Scalar Sequencer

This block drives a separate point-arithmetic unit through the steps of a scalar multiplication Q = [k]P. It does no field or curve arithmetic itself. It takes a scalar and a handle naming the base point. It finds the highest set bit of the scalar and asks the arithmetic unit to load the base point into its accumulator. It then walks the remaining bits from high to low. For each bit it asks for one doubling, and it asks for one addition of the base point when that bit is 1.

Requests go out over a simple request/response handshake, and only one is outstanding at any time. When the walk ends, the block pulses a completion flag. It reports how many doublings, additions and requests in total it issued, so that an integration bench can confirm the operation count. A zero scalar needs no work. The block then signals completion at once, flags the result as the point at infinity and issues nothing.

Top module: `lr_dbladd_seq`

## Requirements
- R1: Bits are consumed from the leading one toward bit 0. After the load request, position i runs from msb−1 down to 0, and each position contributes its requests before any lower position does.
- R2: For a nonzero scalar the first request has op code 3 (load) and carries the base handle latched at start on `req_pt`, so that the accumulator begins equal to P at the leading one.
- R3: Each position below the leading one produces exactly one request with op code 1 (double), with `req_pt` = 0. That request is followed by one request with op code 2 (add), carrying the base handle on `req_pt`, only when bit i of the scalar is 1.
- R4: When `done` pulses for a nonzero scalar, `dbl_cnt` equals the index of the leading one and `add_cnt` equals the number of set bits minus one.
- R5: A zero scalar produces `done` with `result_inf` = 1, no request at all, and all counts equal to 0.
- R6: A request keeps `req_valid`, `req_op` and `req_pt` steady until the cycle in which `rsp_valid` is high. `req_valid` is low in the cycle after that, so at most one operation is outstanding.
- R7: `start` is ignored while `busy` is high. A second start pulse with a different scalar leaves the request sequence and the counts of the running job unchanged.
- R8: `done` is high for exactly one cycle. `dbl_cnt`, `add_cnt`, `op_cnt` and `result_inf` hold their values after it until the next accepted start.
- R9: At `done`, `op_cnt` equals the total number of requests issued: `dbl_cnt` + `add_cnt` + 1 for a nonzero scalar, and 0 for a zero scalar.
- R10: Synchronous active-high reset clears `req_valid`, `done`, `busy`, `result_inf` and all counts, including when it is applied in the middle of a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; sampled only while idle |
| scalar | input | KW | Scalar k, latched at an accepted start |
| base_sel | input | HW | Handle of the base point P, latched at an accepted start |
| req_valid | output | 1 | Operation request pending |
| req_op | output | 2 | Operation: 1 double, 2 add base, 3 load base |
| req_pt | output | HW | Base handle for add/load, 0 for double |
| rsp_valid | input | 1 | Arithmetic unit has completed the pending request |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result_inf | output | 1 | Result is the point at infinity (zero scalar) |
| dbl_cnt | output | $clog2(KW+1) | Doubling requests issued in the current/last job |
| add_cnt | output | $clog2(KW+1) | Addition requests issued in the current/last job |
| op_cnt | output | $clog2(2*KW+1) | All requests issued in the current/last job |

## Verification
The assertions assume that `rsp_valid` is a single-cycle pulse, raised only while `req_valid` is high, so a response never arrives for a request that was not made. The bench acts as the arithmetic unit. It raises `rsp_valid` for one cycle only after it has seen a request, with a programmable wait before it. It treats the group as integers under addition modulo a prime, so the value left in its accumulator must equal k·P at the end. Scalars are chosen to cover a single bit, a lone top bit, all ones, sparse and dense patterns and zero. One job sends a spurious start while busy.

// File: rtl/lr_seq_pkg.sv
package lr_seq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_DBL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_LOAD = 2'd3
  } pt_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FIND,
    S_WAIT,
    S_NEXT
  } seq_st_e;
endpackage

// File: rtl/lr_lead_one.sv
module lr_lead_one #(
  parameter int KW = 16,
  parameter int PW = $clog2(KW)
) (
  input  logic [KW-1:0] vec,
  output logic          found,
  output logic [PW-1:0] idx
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < KW; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/lr_bit_cursor.sv
module lr_bit_cursor #(
  parameter int KW = 16,
  parameter int PW = $clog2(KW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_idx,
  input  logic          step,
  input  logic [KW-1:0] vec,
  output logic [PW-1:0] pos,
  output logic          at_zero,
  output logic          cur_bit
);
  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (load) pos <= load_idx;
    else if (step) pos <= pos - PW'(1);
  end

  assign at_zero = (pos == '0);
  assign cur_bit = vec[pos];

  // R1: the cursor never steps below bit 0
  p_no_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    step |-> (pos != '0));
  p_load_step_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(load && step));
endmodule

// File: rtl/lr_op_counters.sv
module lr_op_counters #(
  parameter int CW = 5,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc_load,
  input  logic          inc_dbl,
  input  logic          inc_add,
  output logic [CW-1:0] dbl_cnt,
  output logic [CW-1:0] add_cnt,
  output logic [OW-1:0] op_cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dbl_cnt <= '0;
      add_cnt <= '0;
      op_cnt  <= '0;
    end else begin
      if (inc_dbl) dbl_cnt <= dbl_cnt + CW'(1);
      if (inc_add) add_cnt <= add_cnt + CW'(1);
      if (inc_load || inc_dbl || inc_add) op_cnt <= op_cnt + OW'(1);
    end
  end

  // R4: counters never wrap within one job
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_dbl |-> dbl_cnt != '1) and (inc_add |-> add_cnt != '1));
  // R6: at most one request issued per cycle
  p_one_issue_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc_load, inc_dbl, inc_add}));
endmodule

// File: rtl/lr_dbladd_seq.sv
module lr_dbladd_seq
  import lr_seq_pkg::*;
#(
  parameter int KW = 16,
  parameter int HW = 4,
  parameter int PW = $clog2(KW),
  parameter int CW = $clog2(KW + 1),
  parameter int OW = $clog2(2 * KW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  input  logic [HW-1:0] base_sel,
  output logic          req_valid,
  output logic [1:0]    req_op,
  output logic [HW-1:0] req_pt,
  input  logic          rsp_valid,
  output logic          busy,
  output logic          done,
  output logic          result_inf,
  output logic [CW-1:0] dbl_cnt,
  output logic [CW-1:0] add_cnt,
  output logic [OW-1:0] op_cnt
);
  seq_st_e       st;
  logic [KW-1:0] k_r;
  logic [HW-1:0] base_r;
  logic [PW-1:0] msb_r;
  pt_op_e        op_q;
  logic          lead_found;
  logic [PW-1:0] lead_idx;
  logic [PW-1:0] pos;
  logic          pos_zero, cur_bit;
  logic          accept, issue_load, issue_dbl, issue_add;

  lr_lead_one #(.KW(KW), .PW(PW)) u_lead (
    .vec(k_r), .found(lead_found), .idx(lead_idx)
  );

  lr_bit_cursor #(.KW(KW), .PW(PW)) u_cursor (
    .clk(clk), .rst(rst), .load(issue_load), .load_idx(lead_idx),
    .step(issue_dbl), .vec(k_r), .pos(pos), .at_zero(pos_zero),
    .cur_bit(cur_bit)
  );

  lr_op_counters #(.CW(CW), .OW(OW)) u_cnt (
    .clk(clk), .rst(rst), .clr(accept), .inc_load(issue_load),
    .inc_dbl(issue_dbl), .inc_add(issue_add),
    .dbl_cnt(dbl_cnt), .add_cnt(add_cnt), .op_cnt(op_cnt)
  );

  always_comb begin
    accept     = (st == S_IDLE) && start;
    issue_load = (st == S_FIND) && lead_found;
    issue_add  = (st == S_NEXT) && (op_q == OP_DBL) && cur_bit;
    issue_dbl  = (st == S_NEXT) && !issue_add && !pos_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      k_r        <= '0;
      base_r     <= '0;
      msb_r      <= '0;
      op_q       <= OP_IDLE;
      req_valid  <= 1'b0;
      req_pt     <= '0;
      done       <= 1'b0;
      result_inf <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            k_r        <= scalar;
            base_r     <= base_sel;
            result_inf <= 1'b0;
            st         <= S_FIND;
          end
        end
        S_FIND: begin
          if (!lead_found) begin
            done       <= 1'b1;
            result_inf <= 1'b1;
            st         <= S_IDLE;
          end else begin
            msb_r     <= lead_idx;
            op_q      <= OP_LOAD;
            req_pt    <= base_r;
            req_valid <= 1'b1;
            st        <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rsp_valid) begin
            req_valid <= 1'b0;
            st        <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (issue_add) begin
            op_q      <= OP_ADD;
            req_pt    <= base_r;
            req_valid <= 1'b1;
            st        <= S_WAIT;
          end else if (pos_zero) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            op_q      <= OP_DBL;
            req_pt    <= '0;
            req_valid <= 1'b1;
            st        <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_op = op_q;
  assign busy   = (st != S_IDLE);

  // R6: request held steady until answered
  p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_op) && $stable(req_pt)));
  // R6: a gap follows every response
  p_gap_after_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_valid) |=> !req_valid);
  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: zero scalar issues nothing
  p_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (done && result_inf) |-> (op_cnt == '0));
  // R4: doubling count matches leading-one index
  p_dbl_exact_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !result_inf) |-> (dbl_cnt == CW'(msb_r)));
  // R9: total equals parts
  p_ops_sum_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (op_cnt == OW'(dbl_cnt) + OW'(add_cnt) + OW'(!result_inf)));
  // R7: no request while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
  // R2: a new job always opens with a load
  p_first_load_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && op_cnt == OW'(1)) |-> (req_op == 2'd3));
endmodule

// File: tb/tb_lr_dbladd_seq.sv
module tb_lr_dbladd_seq;
  localparam int KW = 16;
  localparam int HW = 4;
  localparam int CW = $clog2(KW + 1);
  localparam int OW = $clog2(2 * KW + 1);
  localparam longint MODP = 10007;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic [HW-1:0] base_sel = '0;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [HW-1:0] req_pt;
  logic          rsp_valid = 1'b0;
  logic          busy, done, result_inf;
  logic [CW-1:0] dbl_cnt, add_cnt;
  logic [OW-1:0] op_cnt;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lr_dbladd_seq #(.KW(KW), .HW(HW)) dut (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar), .base_sel(base_sel),
    .req_valid(req_valid), .req_op(req_op), .req_pt(req_pt),
    .rsp_valid(rsp_valid), .busy(busy), .done(done), .result_inf(result_inf),
    .dbl_cnt(dbl_cnt), .add_cnt(add_cnt), .op_cnt(op_cnt)
  );

  // {scalar, wait cycles, handle}
  localparam logic [23:0] VECS [8] = '{
    24'h0001_0_1, 24'h8000_1_2, 24'hFFFF_0_3, 24'hA5A5_2_4,
    24'h0002_3_5, 24'h0003_0_6, 24'h1234_1_7, 24'h7FFF_2_8
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [KW-1:0] k, input int lat, input logic [HW-1:0] h,
                          input bit poke);
    logic [1:0] eop [64];
    int n_exp, ne, msb, pc, guard;
    longint pv, acc, want;
    bit fin;
    logic [1:0] op_seen;
    logic [HW-1:0] pt_seen;
    n_exp = 0; msb = -1; pc = 0;
    for (int i = 0; i < KW; i++) if (k[i]) begin msb = i; pc++; end
    if (msb >= 0) begin
      eop[0] = 2'd3; n_exp = 1;
      for (int i = msb - 1; i >= 0; i--) begin
        eop[n_exp] = 2'd1; n_exp++;
        if (k[i]) begin eop[n_exp] = 2'd2; n_exp++; end
      end
    end
    pv = 3 + 7 * longint'(h); acc = 0; ne = 0;
    @(negedge clk); start = 1'b1; scalar = k; base_sel = h;
    @(negedge clk); start = 1'b0;
    fin = 0; guard = 0;
    while (!fin && guard < 3000) begin
      if (done) fin = 1;
      else if (req_valid) begin
        // R1 R2 R3: op order
        chk(ne < n_exp && req_op == eop[ne], "R1 op order", req_op, (ne < n_exp) ? eop[ne] : -1);
        if (req_op == 2'd1) chk(req_pt == '0, "R3 dbl operand", req_pt, 0);
        else chk(req_pt == h, "R2 base handle", req_pt, h);
        op_seen = req_op; pt_seen = req_pt;
        for (int j = 0; j < lat; j++) begin
          if (poke && ne == 0 && j == 0) begin start = 1'b1; scalar = ~k; base_sel = ~h; end
          @(negedge clk); guard++;
          start = 1'b0; scalar = k; base_sel = h;
          chk(req_valid && req_op == op_seen && req_pt == pt_seen, "R6 hold", req_op, op_seen);
        end
        rsp_valid = 1'b1;
        case (op_seen)
          2'd3: acc = pv;
          2'd1: acc = (2 * acc) % MODP;
          2'd2: acc = (acc + pv) % MODP;
          default: acc = -1;
        endcase
        @(negedge clk); guard++;
        rsp_valid = 1'b0;
        chk(!req_valid, "R6 gap", req_valid, 0);
        ne++;
      end else begin
        @(negedge clk); guard++;
      end
    end
    chk(fin, "R1 watchdog", guard, 0);
    want = (longint'(k) * pv) % MODP;
    chk(ne == n_exp, "R1 request count", ne, n_exp);
    chk(int'(dbl_cnt) == ((msb > 0) ? msb : 0), "R4 dbl count", dbl_cnt, (msb > 0) ? msb : 0);
    chk(int'(add_cnt) == ((pc > 0) ? pc - 1 : 0), "R4 add count", add_cnt, (pc > 0) ? pc - 1 : 0);
    chk(int'(op_cnt) == n_exp, "R9 op count", op_cnt, n_exp);
    chk(result_inf == (k == '0), "R5 inf flag", result_inf, (k == '0));
    if (k != '0) chk(acc == want, "R1 result value", acc, want);
    else chk(ne == 0, "R5 no request", ne, 0);
    @(negedge clk);
    chk(!done, "R8 done pulse", done, 0);
    chk(int'(op_cnt) == n_exp && result_inf == (k == '0), "R8 hold counts", op_cnt, n_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(!req_valid && !done && !busy && !result_inf, "R10 reset outputs", {req_valid, done, busy}, 0);
    chk(dbl_cnt == '0 && add_cnt == '0 && op_cnt == '0, "R10 reset counts", op_cnt, 0);

    for (int v = 0; v < 8; v++)
      run_case(VECS[v][23:8], int'(VECS[v][7:4]), VECS[v][3:0], 1'b0);

    // R5: zero scalar
    run_case('0, 0, 4'd9, 1'b0);
    // R7: start while busy is ignored
    run_case(16'h00B6, 3, 4'd10, 1'b1);
    // R3: alternating bits, no wait
    run_case(16'h5555, 0, 4'd11, 1'b0);

    // R10: reset during a job
    @(negedge clk); start = 1'b1; scalar = 16'h0F0F; base_sel = 4'd2;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!req_valid && !busy && !done, "R10 mid-job reset", {req_valid, busy}, 0);
    chk(op_cnt == '0, "R10 mid-job counts", op_cnt, 0);
    run_case(16'h0009, 1, 4'd3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule